// File: doc/BRIEF.md
# Serial Flash Transfer Engine

This block moves bytes between a register-bus host and a serial flash device, one phase at a time. Software chooses a direction, a lane width of one, two or four data lines and a byte count, then sets a start bit. The engine shifts bytes out of, or into, an eight-entry byte FIFO that software fills or drains through a data port register. A programmable divider sets the serial clock rate. Clock polarity and clock phase are selectable. A done flag marks the end of each phase.

A complete flash operation, such as an opcode followed by an address, dummy cycles and data, is built by software from several such phases. While these run, software holds the chip enable low by hand. In automatic mode the engine asserts chip enable itself for the length of one phase.

Top module: `sflash_xfer_engine`

## Requirements
- R1: After reset, the registers at 0x00, 0x10, 0x20 and 0x28 read 0. `sck` is 0, `cs_n` is 1, `irq` is 0 and `io_oe` is 0.
- R2: Each serial clock half period lasts exactly (divider+1) input clock cycles, where the divider is taken from bits [10:0] of register 0x00. Whenever no byte is shifting, `sck` rests at the polarity bit, bit 13 of 0x00.
- R3: Data moves MSB first. With the phase bit (bit 12 of 0x00) clear, a device capturing on the leading clock edge sees the correct bits. With the phase bit set, a device capturing on the trailing clock edge sees the correct bits.
- R4: The width field, bits [5:4] of 0x10, selects the number of lanes: 0 gives one lane, 1 gives two lanes and 2 gives four lanes. One-lane transmit drives `io_out[0]` and one-lane receive samples `io_in[1]`. Multi-lane modes use `io[1:0]` or `io[3:0]`, and the higher lane carries the earlier bit.
- R5: Writing 0x10 with bit 15 set starts a phase of (register 0x14) bytes. Bits [1:0] = 01 select receive and any other value selects transmit. Bit 15 reads 1 while the phase runs and clears on the same edge that sets the done flag. A count of 0 finishes without any clock edge.
- R6: The FIFO holds 8 bytes. Bits [3:0] of 0x20 report the fill level. Any write to 0x20 empties the FIFO. A write to the port at 0x18 while the FIFO is full is dropped.
- R7: In transmit, the serial clock stalls at its idle level while the FIFO is empty, and it resumes when a byte arrives.
- R8: In receive, each byte is pushed into the FIFO and can be read from 0x18. The clock stalls while the FIFO is full, so no byte is lost.
- R9: Bit 14 of 0x08 moves input sampling to the second half of each bit period. Received data stays correct in every clock mode.
- R10: Bit 0 of 0x28 is the done flag. It is cleared by writing 0x28 with bit 0 at 0, and a write with bit 0 at 1 leaves it set. Bit 2 of 0x28 is set in receive mode when the fill level reaches 2^(bits [13:12] of 0x10). `irq` is the OR of each status bit with the matching enable bit in 0x2C.
- R11: With bit 1 of 0x04 set, `cs_n` equals bit 0 of 0x04, even during a phase. With bit 1 clear, `cs_n` is low exactly while a phase is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO when it reads 0x18) |
| reg_addr | input | 6 | Byte address of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip enable, active low |
| io_out | output | 4 | Data lane outputs |
| io_oe | output | 4 | Data lane output enables |
| io_in | input | 4 | Data lane inputs |

## Verification
The bench models a flash device that captures and drives lanes on the edges that clock polarity and clock phase dictate. It sweeps every lane width against every clock mode at two divider settings, and compares the bit stream with the bytes it queued. A swapped phase, a reversed bit order or a wrong lane mapping shows up there as shifted or scrambled data, and a miscounted divider shows up as a wrong half-period time.

Several other corner cases get their own tests. A transmit phase is started on an empty FIFO, and a receive phase runs longer than the FIFO depth; a design that does not stall would clock out garbage or drop bytes. A zero count, an overfilled FIFO, a flush and the manual chip-enable override are each tested, so an engine that clocks on a zero count or accepts a ninth byte is caught.

// File: rtl/sfx_pkg.sv
`timescale 1ns/1ps
package sfx_pkg;

   // register byte offsets
   localparam int OFS_SCTRL = 'h00;
   localparam int OFS_CECTL = 'h04;
   localparam int OFS_DLY   = 'h08;
   localparam int OFS_MMAP  = 'h0C;
   localparam int OFS_XCTL  = 'h10;
   localparam int OFS_XCNT  = 'h14;
   localparam int OFS_PORT  = 'h18;
   localparam int OFS_FPTR  = 'h20;
   localparam int OFS_STAT  = 'h28;
   localparam int OFS_IEN   = 'h2C;

   // direction code that selects receive
   localparam logic [1:0] DIR_RX = 2'b01;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LOAD  = 2'd1,
      ST_SHIFT = 2'd2
   } sfx_state_e;

   // lanes used by a width code (code 3 behaves as four lanes)
   function automatic logic [2:0] lanes_of(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/sfx_clk_div.sv
`timescale 1ns/1ps
module sfx_clk_div #(
   parameter int DIV_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);

   logic [DIV_W-1:0] cnt_q;

   initial begin
      assert (DIV_W >= 1 && DIV_W <= 16) else $error("sfx_clk_div: DIV_W out of range");
   end

   assign tick = run && (cnt_q == div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt_q <= '0;
      else if (!run)       cnt_q <= '0;
      else if (cnt_q == div) cnt_q <= '0;
      else                 cnt_q <= cnt_q + 1'b1;
   end

   // R2
   cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= div));

endmodule

// File: rtl/sfx_byte_fifo.sv
`timescale 1ns/1ps
module sfx_byte_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 8,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             flush,
   input  logic             push,
   input  logic [W-1:0]     wdata,
   input  logic             pop,
   output logic [W-1:0]     rdata,
   output logic [LVL_W-1:0] level,
   output logic             full,
   output logic             empty
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

   logic [W-1:0]     mem_q [DEPTH];
   logic [PTR_W-1:0] wr_q, rd_q;
   logic [LVL_W-1:0] lvl_q;
   logic             do_push, do_pop;

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 15) else $error("sfx_byte_fifo: DEPTH out of range");
      assert (LVL_W >= $clog2(DEPTH + 1)) else $error("sfx_byte_fifo: LVL_W too small");
   end

   assign full    = (lvl_q == LVL_W'(DEPTH));
   assign empty   = (lvl_q == '0);
   assign level   = lvl_q;
   assign rdata   = mem_q[rd_q];
   assign do_push = push && !full && !flush;
   assign do_pop  = pop && !empty && !flush;

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk) begin
         if (do_push && wr_q == PTR_W'(e)) mem_q[e] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
      end else if (flush) begin
         wr_q  <= '0;
         rd_q  <= '0;
         lvl_q <= '0;
      end else begin
         if (do_push) wr_q <= (wr_q == LAST) ? '0 : wr_q + 1'b1;
         if (do_pop)  rd_q <= (rd_q == LAST) ? '0 : rd_q + 1'b1;
         if (do_push && !do_pop)      lvl_q <= lvl_q + 1'b1;
         else if (do_pop && !do_push) lvl_q <= lvl_q - 1'b1;
      end
   end

   // R6
   level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R6
   flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> empty);

endmodule

// File: rtl/sfx_shifter.sv
`timescale 1ns/1ps
module sfx_shifter
   import sfx_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             rx_mode,
   input  logic [1:0]       lw,
   input  logic             cpol,
   input  logic             cpha,
   input  logic             late_smp,
   input  logic [CNT_W-1:0] nbytes,
   input  logic             tick,
   input  logic             fifo_empty,
   input  logic             fifo_full,
   input  logic [7:0]       fifo_head,
   input  logic [3:0]       io_in,
   output logic             run,
   output logic             busy,
   output logic             done,
   output logic             fifo_pop,
   output logic             fifo_push,
   output logic [7:0]       push_byte,
   output logic             sck,
   output logic [3:0]       io_out,
   output logic [3:0]       io_oe
);

   sfx_state_e       st_q;
   logic [CNT_W-1:0] left_q;
   logic [2:0]       beat_q;
   logic             half_q;
   logic [7:0]       tx_q, rx_q;
   logic [7:0]       tx_nxt, rx_nxt;
   logic [2:0]       lanes, last_beat;
   logic             have_bytes, can_load, byte_end;

   initial begin
      assert (CNT_W >= 1 && CNT_W <= 32) else $error("sfx_shifter: CNT_W out of range");
   end

   assign lanes      = lanes_of(lw);
   assign last_beat  = (lanes == 3'd1) ? 3'd7 : (lanes == 3'd2) ? 3'd3 : 3'd1;
   assign have_bytes = (left_q != '0);
   assign can_load   = rx_mode ? !fifo_full : !fifo_empty;
   assign byte_end   = (st_q == ST_SHIFT) && tick && half_q && (beat_q == last_beat);

   assign busy      = (st_q != ST_IDLE);
   assign run       = (st_q == ST_SHIFT);
   assign done      = (st_q == ST_LOAD) && !have_bytes;
   assign fifo_pop  = (st_q == ST_LOAD) && have_bytes && !rx_mode && !fifo_empty;
   assign fifo_push = byte_end && rx_mode;
   assign push_byte = late_smp ? rx_nxt : rx_q;
   assign sck       = run ? (cpol ^ cpha ^ half_q) : cpol;

   always_comb begin
      case (lanes)
         3'd1: begin
            rx_nxt = {rx_q[6:0], io_in[1]};
            tx_nxt = {tx_q[6:0], 1'b0};
         end
         3'd2: begin
            rx_nxt = {rx_q[5:0], io_in[1:0]};
            tx_nxt = {tx_q[5:0], 2'b00};
         end
         default: begin
            rx_nxt = {rx_q[3:0], io_in[3:0]};
            tx_nxt = {tx_q[3:0], 4'h0};
         end
      endcase
   end

   // per-lane output mapping: lane g carries bit (8 - lanes + g) of the byte
   for (genvar g = 0; g < 4; g++) begin : g_lane
      logic in_use;
      assign in_use    = (3'(g) < lanes);
      assign io_oe[g]  = busy && !rx_mode && in_use;
      assign io_out[g] = in_use ? tx_q[3'(8 - int'(lanes) + g)] : 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         beat_q <= '0;
         half_q <= 1'b0;
         tx_q   <= '0;
         rx_q   <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  left_q <= nbytes;
                  st_q   <= ST_LOAD;
               end
            end
            ST_LOAD: begin
               if (!have_bytes) begin
                  st_q <= ST_IDLE;
               end else if (can_load) begin
                  st_q   <= ST_SHIFT;
                  beat_q <= '0;
                  half_q <= 1'b0;
                  rx_q   <= '0;
                  if (!rx_mode) tx_q <= fifo_head;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  if (!half_q) begin
                     half_q <= 1'b1;
                     if (!late_smp) rx_q <= rx_nxt;
                  end else begin
                     half_q <= 1'b0;
                     if (late_smp) rx_q <= rx_nxt;
                     if (beat_q == last_beat) begin
                        st_q   <= ST_LOAD;
                        left_q <= left_q - 1'b1;
                     end else begin
                        beat_q <= beat_q + 1'b1;
                        tx_q   <= tx_nxt;
                     end
                  end
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   half_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && half_q != $past(half_q)) |-> $past(tick));

   // R8
   no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_push |-> !fifo_full);

   // R7
   tx_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !run && !rx_mode && fifo_empty) |=> (!run || $past(!have_bytes)) );

endmodule

// File: rtl/sflash_xfer_engine.sv
`timescale 1ns/1ps
module sflash_xfer_engine
   import sfx_pkg::*;
#(
   parameter int DIV_W      = 11,
   parameter int FIFO_DEPTH = 8,
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              irq,
   output logic              sck,
   output logic              cs_n,
   output logic [3:0]        io_out,
   output logic [3:0]        io_oe,
   input  logic [3:0]        io_in
);

   localparam int LVL_W = $clog2(FIFO_DEPTH + 1);

   initial begin
      assert (ADDR_W >= 6) else $error("sflash_xfer_engine: ADDR_W must cover 0x2C");
      assert (DIV_W <= 11) else $error("sflash_xfer_engine: divider field is 11 bits");
      assert (LVL_W <= 4) else $error("sflash_xfer_engine: fill field is 4 bits");
   end

   // configuration state
   logic [DIV_W-1:0] div_q;
   logic             cpha_q, cpol_q, ce_man_q, ce_val_q, late_q;
   logic [1:0]       dir_q, lw_q, trig_q;
   logic [CNT_W-1:0] cnt_q;
   logic             done_q, en_done_q, en_rx_q;

   // engine and FIFO wiring
   logic             busy, done, run, tick, start;
   logic             eng_pop, eng_push, sw_push, sw_pop, flush;
   logic [7:0]       eng_byte, head, f_wdata;
   logic [LVL_W-1:0] level;
   logic             f_full, f_empty, rx_mode, rx_avail;
   logic             unused_wdata;

   function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
      return a == ADDR_W'(ofs);
   endfunction

   assign unused_wdata = ^reg_wdata;
   assign rx_mode = (dir_q == DIR_RX);
   assign start   = reg_wr && hit(reg_addr, OFS_XCTL) && reg_wdata[15] && !busy;
   assign flush   = reg_wr && hit(reg_addr, OFS_FPTR);
   assign sw_push = reg_wr && hit(reg_addr, OFS_PORT) && !eng_push;
   assign sw_pop  = reg_rd && hit(reg_addr, OFS_PORT) && !eng_pop;
   assign f_wdata = eng_push ? eng_byte : reg_wdata[7:0];

   always_comb begin
      int thr;
      thr = 1 << trig_q;
      if (thr > FIFO_DEPTH) thr = FIFO_DEPTH;
      rx_avail = rx_mode && (int'(level) >= thr);
   end

   assign irq  = (done_q && en_done_q) || (rx_avail && en_rx_q);
   assign cs_n = ce_man_q ? ce_val_q : !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q     <= '0;
         cpha_q    <= 1'b0;
         cpol_q    <= 1'b0;
         ce_man_q  <= 1'b0;
         ce_val_q  <= 1'b0;
         late_q    <= 1'b0;
         dir_q     <= '0;
         lw_q      <= '0;
         trig_q    <= '0;
         cnt_q     <= '0;
         done_q    <= 1'b0;
         en_done_q <= 1'b0;
         en_rx_q   <= 1'b0;
      end else begin
         if (reg_wr) begin
            if (hit(reg_addr, OFS_SCTRL)) begin
               div_q  <= reg_wdata[DIV_W-1:0];
               cpha_q <= reg_wdata[12];
               cpol_q <= reg_wdata[13];
            end
            if (hit(reg_addr, OFS_CECTL)) begin
               ce_val_q <= reg_wdata[0];
               ce_man_q <= reg_wdata[1];
            end
            if (hit(reg_addr, OFS_DLY)) late_q <= reg_wdata[14];
            if (hit(reg_addr, OFS_XCTL) && !busy) begin
               dir_q  <= reg_wdata[1:0];
               lw_q   <= reg_wdata[5:4];
               trig_q <= reg_wdata[13:12];
            end
            if (hit(reg_addr, OFS_XCNT)) cnt_q <= reg_wdata[CNT_W-1:0];
            if (hit(reg_addr, OFS_STAT) && !reg_wdata[0]) done_q <= 1'b0;
            if (hit(reg_addr, OFS_IEN)) begin
               en_done_q <= reg_wdata[0];
               en_rx_q   <= reg_wdata[2];
            end
         end
         if (done) done_q <= 1'b1;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         OFS_SCTRL: reg_rdata = {18'b0, cpol_q, cpha_q, 1'b0, 11'(div_q)};
         OFS_CECTL: reg_rdata = {30'b0, ce_man_q, ce_val_q};
         OFS_DLY:   reg_rdata = {17'b0, late_q, 14'b0};
         OFS_XCTL:  reg_rdata = {16'b0, busy, 1'b0, trig_q, 6'b0, lw_q, 2'b0, dir_q};
         OFS_XCNT:  reg_rdata = 32'(cnt_q);
         OFS_PORT:  reg_rdata = f_empty ? 32'd0 : {24'b0, head};
         OFS_FPTR:  reg_rdata = 32'(level);
         OFS_STAT:  reg_rdata = {29'b0, rx_avail, 1'b0, done_q};
         OFS_IEN:   reg_rdata = {29'b0, en_rx_q, 1'b0, en_done_q};
         default:   reg_rdata = '0;
      endcase
   end

   sfx_clk_div #(.DIV_W(DIV_W)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (div_q),
      .tick (tick)
   );

   sfx_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8), .LVL_W(LVL_W)) u_fifo (
      .clk  (clk),
      .rst_n(rst_n),
      .flush(flush),
      .push (eng_push || sw_push),
      .wdata(f_wdata),
      .pop  (eng_pop || sw_pop),
      .rdata(head),
      .level(level),
      .full (f_full),
      .empty(f_empty)
   );

   sfx_shifter #(.CNT_W(CNT_W)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rx_mode   (rx_mode),
      .lw        (lw_q),
      .cpol      (cpol_q),
      .cpha      (cpha_q),
      .late_smp  (late_q),
      .nbytes    (cnt_q),
      .tick      (tick),
      .fifo_empty(f_empty),
      .fifo_full (f_full),
      .fifo_head (head),
      .io_in     (io_in),
      .run       (run),
      .busy      (busy),
      .done      (done),
      .fifo_pop  (eng_pop),
      .fifo_push (eng_push),
      .push_byte (eng_byte),
      .sck       (sck),
      .io_out    (io_out),
      .io_oe     (io_oe)
   );

   // R5
   go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_q);

   // R11
   cs_auto_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ce_man_q && sck != cpol_q) |-> !cs_n);

   // R2
   sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (sck == cpol_q));

endmodule

// File: tb/sflash_xfer_engine_bench.sv
`timescale 1ns/1ps
module sflash_xfer_engine_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq, sck, cs_n;
   logic [3:0]  io_out, io_oe;
   logic [3:0]  io_in = '0;

   int checks = 0;
   int errors = 0;

   // device model state
   logic         m_en = 1'b0;
   logic         m_cpol = 1'b0, m_cpha = 1'b0;
   int           m_nb = 1;
   logic [127:0] cap = '0;
   int           cap_n = 0;
   logic [127:0] src = '0;
   int           src_idx = 0;
   int           edge_n = 0;
   realtime      t_e0 = 0, t_e1 = 0;

   always #2.5 clk = ~clk;

   sflash_xfer_engine u_sflash_xfer_engine (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .irq(irq), .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe),
      .io_in(io_in)
   );

   task automatic present();
      io_in = '0;
      for (int k = 0; k < m_nb; k++) begin
         int idx;
         idx = src_idx - (m_nb - 1 - k);
         if (idx >= 0) io_in[(m_nb == 1) ? 1 : k] = src[idx];
      end
   endtask

   always @(sck) begin
      if (m_en) begin
         logic lead;
         if (edge_n == 0) t_e0 = $realtime;
         if (edge_n == 1) t_e1 = $realtime;
         edge_n++;
         lead = (sck != m_cpol);
         if (m_cpha ? !lead : lead) begin
            for (int k = m_nb - 1; k >= 0; k--) begin
               cap = {cap[126:0], io_out[k]};
               cap_n++;
            end
         end
         if (m_cpha && lead) begin
            present();
            src_idx -= m_nb;
         end
         if (!m_cpha && !lead) begin
            src_idx -= m_nb;
            present();
         end
      end
   end

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = 6'(a); reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = 6'(a); reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int n = 0; n < 20000; n++) begin
         rd('h10, v);
         if (!v[15]) break;
      end
   endtask

   task automatic model_setup(input logic pol, input logic pha, input int nb);
      m_cpol = pol; m_cpha = pha; m_nb = nb;
      cap = '0; cap_n = 0; edge_n = 0;
      m_en = 1'b1;
   endtask

   function automatic logic [7:0] pat(input int r, input int k);
      return 8'(r * 37 + k * 91 + 5);
   endfunction

   task automatic tx_run(input int lw, input int mode, input int div, input int r);
      logic [127:0] exp;
      logic [31:0]  v;
      int           n;
      n = 3;
      exp = '0;
      wr('h00, 32'((mode[1] << 13) | (mode[0] << 12) | div));
      wr('h08, 0);
      wr('h20, 0);
      model_setup(mode[1], mode[0], 1 << lw);
      for (int k = 0; k < n; k++) begin
         wr('h18, 32'(pat(r, k)));
         exp = {exp[119:0], pat(r, k)};
      end
      wr('h14, n);
      wr('h10, 32'((1 << 15) | (lw << 4) | 2));
      wait_idle();
      chk($sformatf("R3 R4 tx stream lw=%0d mode=%0d", lw, mode), cap, exp);
      chk("R4 tx bit count", 128'(cap_n), 128'(8 * n));
      chk($sformatf("R2 half period div=%0d", div), 128'(int'(t_e1 - t_e0)), 128'((div + 1) * 5));
      rd('h28, v);
      chk("R5 done after tx", 128'(v[0]), 128'(1));
      wr('h28, 0);
      m_en = 1'b0;
   endtask

   task automatic rx_run(input int lw, input int mode, input logic late, input int r);
      logic [31:0] v;
      int          n;
      n = 3;
      wr('h00, 32'((mode[1] << 13) | (mode[0] << 12) | 1));
      wr('h08, 32'(late) << 14);
      wr('h20, 0);
      model_setup(mode[1], mode[0], 1 << lw);
      src = '0;
      for (int k = 0; k < n; k++) src = {src[119:0], pat(r, k)};
      src_idx = 8 * n - 1;
      if (!mode[0]) present();
      wr('h14, n);
      wr('h10, 32'((1 << 15) | (lw << 4) | 1));
      wait_idle();
      rd('h20, v);
      chk("R8 rx fill level", 128'(v[3:0]), 128'(n));
      for (int k = 0; k < n; k++) begin
         rd('h18, v);
         chk($sformatf("R8 R9 rx byte lw=%0d mode=%0d late=%0d", lw, mode, late),
             128'(v[7:0]), 128'(pat(r, k)));
      end
      wr('h28, 0);
      m_en = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      rd('h00, v); chk("R1 sctrl reset", 128'(v), 0);
      rd('h10, v); chk("R1 xctl reset", 128'(v), 0);
      rd('h20, v); chk("R1 fill reset", 128'(v), 0);
      rd('h28, v); chk("R1 status reset", 128'(v), 0);
      chk("R1 pins reset", 128'({sck, cs_n, irq, io_oe}), 128'({1'b0, 1'b1, 1'b0, 4'h0}));

      // R2 R3 R4: sweep width x mode x divider
      r = 0;
      for (int lw = 0; lw < 3; lw++)
         for (int mode = 0; mode < 4; mode++)
            for (int d = 0; d < 2; d++) begin
               tx_run(lw, mode, d * 3, r);
               r++;
            end

      // R8 R9: receive sweep
      for (int lw = 0; lw < 3; lw++)
         for (int mi = 0; mi < 2; mi++)
            for (int late = 0; late < 2; late++) begin
               rx_run(lw, mi * 3, 1'(late), r);
               r++;
            end

      // R7 transmit stall on empty FIFO, with automatic chip enable (R11)
      wr('h00, 1);
      wr('h08, 0);
      wr('h20, 0);
      model_setup(1'b0, 1'b0, 1);
      wr('h14, 2);
      wr('h10, 32'((1 << 15) | 2));
      repeat (20) @(negedge clk);
      rd('h10, v);
      chk("R7 busy while starved", 128'(v[15]), 1);
      chk("R7 sck idle while starved", 128'({sck, 8'(edge_n)}), 0);
      chk("R11 auto cs low while active", 128'(cs_n), 0);
      wr('h18, 32'h5A);
      wr('h18, 32'hC3);
      wait_idle();
      chk("R7 stream after stall", cap, 128'(16'h5AC3));
      chk("R11 auto cs high after phase", 128'(cs_n), 1);
      m_en = 1'b0;

      // R10 status and irq
      wr('h2C, 1);
      chk("R10 irq on done", 128'(irq), 1);
      wr('h28, 1);
      rd('h28, v);
      chk("R10 write 1 keeps done", 128'(v[0]), 1);
      wr('h28, 0);
      rd('h28, v);
      chk("R10 write 0 clears done", 128'(v[0]), 0);
      chk("R10 irq drops", 128'(irq), 0);
      wr('h2C, 0);

      // R5 zero count
      model_setup(1'b0, 1'b0, 1);
      wr('h14, 0);
      wr('h10, 32'((1 << 15) | 2));
      wait_idle();
      rd('h28, v);
      chk("R5 zero count done", 128'(v[0]), 1);
      chk("R5 zero count no edges", 128'(edge_n), 0);
      wr('h28, 0);
      m_en = 1'b0;

      // R6 full FIFO drops extra write, flush empties
      wr('h10, 2);
      wr('h20, 0);
      for (int k = 0; k < 9; k++) wr('h18, 32'(pat(99, k)));
      rd('h20, v);
      chk("R6 fill saturates at 8", 128'(v[3:0]), 8);
      model_setup(1'b0, 1'b0, 4);
      wr('h14, 8);
      wr('h10, 32'((1 << 15) | (2 << 4) | 2));
      wait_idle();
      begin
         logic [127:0] exp;
         exp = '0;
         for (int k = 0; k < 8; k++) exp = {exp[119:0], pat(99, k)};
         chk("R6 ninth byte dropped", cap, exp);
      end
      m_en = 1'b0;
      wr('h18, 32'h11);
      wr('h18, 32'h22);
      wr('h20, 0);
      rd('h20, v);
      chk("R6 flush empties", 128'(v[3:0]), 0);
      wr('h28, 0);

      // R8 receive stall when full, R10 rx available
      wr('h00, 0);
      wr('h08, 0);
      model_setup(1'b0, 1'b0, 4);
      src = '0;
      for (int k = 0; k < 10; k++) src = {src[119:0], pat(7, k)};
      src_idx = 79;
      present();
      wr('h2C, 4);
      wr('h14, 10);
      wr('h10, 32'((1 << 15) | (3 << 12) | (2 << 4) | 1));
      repeat (300) @(negedge clk);
      rd('h20, v);
      chk("R8 fill stops at 8", 128'(v[3:0]), 8);
      rd('h10, v);
      chk("R8 busy while full", 128'(v[15]), 1);
      rd('h28, v);
      chk("R10 rx available at trigger", 128'(v[2]), 1);
      chk("R10 irq from rx available", 128'(irq), 1);
      for (int k = 0; k < 10; k++) begin
         for (int n = 0; n < 200; n++) begin
            rd('h20, v);
            if (v[3:0] != 0) break;
         end
         rd('h18, v);
         chk("R8 rx byte across stall", 128'(v[7:0]), 128'(pat(7, k)));
      end
      wait_idle();
      rd('h28, v);
      chk("R10 rx available drops when drained", 128'(v[2:0]), 128'(3'b001));
      wr('h28, 0);
      wr('h2C, 0);
      m_en = 1'b0;

      // R11 manual chip enable
      wr('h04, 2);
      chk("R11 manual low", 128'(cs_n), 0);
      wr('h04, 3);
      chk("R11 manual high", 128'(cs_n), 1);
      wr('h04, 2);
      wr('h20, 0);
      wr('h18, 32'hA5);
      wr('h14, 1);
      wr('h10, 32'((1 << 15) | 2));
      wait_idle();
      chk("R11 manual low held after phase", 128'(cs_n), 0);
      wr('h04, 0);
      chk("R11 auto idle high", 128'(cs_n), 1);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule